// File: doc/BRIEF.md
# Two-Wire Control Register Target

This block lets an external host read and write a bank of 8-bit control registers over a two-wire serial bus (I2C), acting only as a target. The bus clock and data lines arrive asynchronously. The block samples them with its own core clock through two-flop synchronizers and edge detectors. From the filtered levels and edges it recognises start, repeated-start and stop conditions, and it decodes the frames that follow. The data line is driven through an output-enable only: when the enable is high the pad pulls the line low, otherwise the line floats high on its pull-up. The clock line is never driven.

A write transfer names a register index and then carries one data byte. A read is done in two steps. The host first writes the index and ends that transfer, with a stop or directly with a repeated start. It then addresses the block again with the read bit set and clocks out one byte. The index register keeps its value across transfers, so the read returns the byte the previous transfer pointed at. Every register has a defined value after the active-low reset. The whole bank is presented as a flat bus to the blocks that use the fields.

Top module: `ctl_i2c_target`

## Requirements
- R1: After reset every register holds its default value. Defaults: 01h=10h, 03h=0Eh, 05h=0Eh, 06h=01h, 07h=20h, 08h=01h, 09h=60h, 0Ah=80h, 0Bh=01h, 0Ch=8Fh, 0Eh=C7h, 11h=01h, 15h=6Fh, 16h=20h, 1Ah=94h, 1Bh=77h, 1Ch=77h, 21h..24h=80h, 25h=14h, 27h=01h, 28h=40h, 2Bh=02h. All other registers are 00h. Register n is exposed on `ctl_regs_o[8n+7:8n]`. The data line is released.
- R2: The first byte after a start is the 7-bit device address 0010001b, sent MSB first and followed by a direction bit (0 = write, 1 = read). On a match the block acknowledges by pulling the data line low for the ninth clock.
- R3: In a write transfer (address+write, index byte, data byte) the block acknowledges both bytes and loads the data byte into the indexed register.
- R4: After address+read, the block shifts out the indexed register MSB first, one bit per clock, changing the line only while the clock is low.
- R5: When the address does not match, nothing is acknowledged and all further bytes are ignored until the next start. No register changes.
- R6: The index is kept across a stop. A read of an index at or above 2Ch returns 00h, and a write to such an index changes no register.
- R7: A transfer carries only one data byte. A second byte in the same write is neither acknowledged nor stored.
- R8: A repeated start without a preceding stop begins a new frame. A read issued this way returns the register selected by the index just written.
- R9: The data-line enable changes only while the synchronized clock is low (start and stop excepted), and a stop always releases the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to sample the bus |
| rst_n | input | 1 | Active-low reset, restores register defaults |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe_o | output | 1 | High pulls the data line low |
| ctl_regs_o | output | NREG*8 | Flat register bank, register n at bits [8n+7:8n] |

## Verification
The hardest case to reach is a read that crosses transfer boundaries. The index must survive a stop or a repeated start, and the returned byte depends on what an earlier transfer stored. The stimulus builds a bench-side model of the bank by chaining random write transfers. Each write is followed by a read-back that alternates between the stop-then-start form and the repeated-start form, at random indices that partly fall beyond the implemented range. Directed sequences add a foreign address with trailing bytes and a write carrying an extra byte, and the whole bank is compared after each of them.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    LK_IDLE,
    LK_ADDR,
    LK_AACK,
    LK_INDEX,
    LK_IACK,
    LK_WDATA,
    LK_DACK,
    LK_TX,
    LK_MACK,
    LK_IGNORE
  } link_state_e;

  // power-up contents of one control register
  function automatic logic [7:0] ctl_default(input int unsigned idx);
    logic [7:0] v;
    case (idx)
      'h01: v = 8'h10;
      'h03, 'h05: v = 8'h0E;
      'h06, 'h08, 'h0B, 'h11, 'h27: v = 8'h01;
      'h07, 'h16: v = 8'h20;
      'h09: v = 8'h60;
      'h0A, 'h21, 'h22, 'h23, 'h24: v = 8'h80;
      'h0C: v = 8'h8F;
      'h0E: v = 8'hC7;
      'h15: v = 8'h6F;
      'h1A: v = 8'h94;
      'h1B, 'h1C: v = 8'h77;
      'h25: v = 8'h14;
      'h28: v = 8'h40;
      'h2B: v = 8'h02;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  // compares the upper seven bits of an address frame with the device address
  function automatic logic addr_hit(input logic [7:0] frame, input logic [6:0] own);
    return frame[7:1] == own;
  endfunction

  function automatic logic index_mapped(input logic [7:0] idx, input int unsigned nreg);
    return 32'(idx) < nreg;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw_i[l]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[l]  = chain_q[STAGES-1];
    assign rise_o[l] = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[l] = ~chain_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_i2c_pkg::*;
#(
  parameter int NREG = 44
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [BYTE_W-1:0]        wr_idx_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  input  logic [BYTE_W-1:0]        rd_idx_i,
  output logic [BYTE_W-1:0]        rd_data_o,
  output logic [NREG*BYTE_W-1:0]   bank_o
);

  logic [BYTE_W-1:0] regs_q [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[r] <= ctl_default(r);
      end else if (wr_en_i && wr_idx_i == BYTE_W'(r)) begin
        regs_q[r] <= wr_data_i;
      end
    end
    assign bank_o[r*BYTE_W +: BYTE_W] = regs_q[r];
  end

  // unmapped indices read back as zero
  always_comb begin
    rd_data_o = '0;
    for (int r = 0; r < NREG; r++) begin
      if (rd_idx_i == BYTE_W'(r)) rd_data_o = regs_q[r];
    end
  end

  // R6: a write to an index beyond the bank leaves every register untouched
  assert_unmapped_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !index_mapped(wr_idx_i, NREG)) |=> $stable(bank_o));

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
  import ctl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [BYTE_W-1:0] idx_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  link_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] idx_q;
  logic              rw_q;

  // named bus events, also used by the assertions
  logic bus_start, bus_stop, byte_done, frame_hit;
  assign bus_start = sda_fall_i & scl_lvl_i;
  assign bus_stop  = sda_rise_i & scl_lvl_i;
  assign byte_done = scl_fall_i && cnt_q == CNT_W'(BYTE_W);
  assign frame_hit = addr_hit(shreg_q, DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      tx_q    <= '0;
      idx_q   <= '0;
      rw_q    <= 1'b0;
    end else if (bus_start) begin
      state_q <= LK_ADDR;
      cnt_q   <= '0;
    end else if (bus_stop) begin
      state_q <= LK_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        LK_ADDR, LK_INDEX, LK_WDATA: begin
          if (scl_rise_i) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
            cnt_q   <= cnt_q + 1'b1;
          end else if (byte_done) begin
            cnt_q <= '0;
            if (state_q == LK_ADDR) begin
              if (frame_hit) begin
                state_q <= LK_AACK;
                rw_q    <= shreg_q[0];
              end else begin
                state_q <= LK_IGNORE;
              end
            end else if (state_q == LK_INDEX) begin
              idx_q   <= shreg_q;
              state_q <= LK_IACK;
            end else begin
              state_q <= LK_DACK;
            end
          end
        end
        LK_AACK: begin
          if (scl_fall_i) begin
            if (rw_q) begin
              state_q <= LK_TX;
              tx_q    <= rd_data_i;
              cnt_q   <= '0;
            end else begin
              state_q <= LK_INDEX;
            end
          end
        end
        LK_IACK: if (scl_fall_i) state_q <= LK_WDATA;
        LK_DACK: if (scl_fall_i) state_q <= LK_IGNORE;
        LK_TX: begin
          if (scl_fall_i) begin
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              state_q <= LK_MACK;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        LK_MACK: if (scl_fall_i) state_q <= LK_IGNORE;
        default: ;
      endcase
    end
  end

  assign wr_en_o   = state_q == LK_WDATA && byte_done && !bus_start && !bus_stop;
  assign wr_data_o = shreg_q;
  assign idx_o     = idx_q;

  always_comb begin
    unique case (state_q)
      LK_AACK, LK_IACK, LK_DACK: sda_oe_o = 1'b1;
      LK_TX:                     sda_oe_o = ~tx_q[BYTE_W-1];
      default:                   sda_oe_o = 1'b0;
    endcase
  end

  // R9: the line enable moves only while the clock is low
  assert_oe_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_o) && !$past(bus_start) && !$past(bus_stop)) |-> !scl_lvl_i);

  // R9: a stop leaves the line released and the frame decoder idle
  assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (state_q == LK_IDLE && !sda_oe_o));

  // R5: a foreign address is never acknowledged
  assert_foreign_no_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_ADDR && byte_done && !frame_hit && !bus_start && !bus_stop) |=> !sda_oe_o);

  // R7: every stored byte is followed by its acknowledge and then no further write
  assert_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (state_q == LK_DACK && !wr_en_o));

endmodule

// File: rtl/ctl_i2c_target.sv
module ctl_i2c_target
  import ctl_i2c_pkg::*;
#(
  parameter int         NREG        = 44,
  parameter logic [6:0] DEV_ADDR    = 7'h11,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic [NREG*BYTE_W-1:0] ctl_regs_o
);

  localparam int SCL_BIT = 1;
  localparam int SDA_BIT = 0;

  logic [1:0]        lvl, rise, fall;
  logic [BYTE_W-1:0] idx, wr_data, rd_data;
  logic              wr_en;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({scl_i, sda_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  i2c_link_fsm #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl_i  (lvl[SCL_BIT]),
    .scl_rise_i (rise[SCL_BIT]),
    .scl_fall_i (fall[SCL_BIT]),
    .sda_lvl_i  (lvl[SDA_BIT]),
    .sda_rise_i (rise[SDA_BIT]),
    .sda_fall_i (fall[SDA_BIT]),
    .rd_data_i  (rd_data),
    .idx_o      (idx),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  ctl_reg_bank #(.NREG(NREG)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (idx),
    .rd_data_o (rd_data),
    .bank_o    (ctl_regs_o)
  );

endmodule

// File: tb/ctl_i2c_target_tb.sv
module ctl_i2c_target_tb_top;

  localparam int NREG = 44;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  logic sda_bus;

  assign sda_bus = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  ctl_i2c_target #(.NREG(NREG)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_bus),
    .sda_oe_o   (sda_oe),
    .ctl_regs_o (regs)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] model [NREG];

  // bench restatement of the power-up table, as (index, value) pairs
  function automatic logic [7:0] power_up(input int i);
    int unsigned tbl [24][2] = '{
      '{'h01,'h10}, '{'h03,'h0E}, '{'h05,'h0E}, '{'h06,'h01}, '{'h07,'h20}, '{'h08,'h01},
      '{'h09,'h60}, '{'h0A,'h80}, '{'h0B,'h01}, '{'h0C,'h8F}, '{'h0E,'hC7}, '{'h11,'h01},
      '{'h15,'h6F}, '{'h16,'h20}, '{'h1A,'h94}, '{'h1B,'h77}, '{'h1C,'h77}, '{'h21,'h80},
      '{'h22,'h80}, '{'h23,'h80}, '{'h24,'h80}, '{'h25,'h14}, '{'h27,'h01}, '{'h28,'h40}};
    if (i == 'h2B) return 8'h02;
    for (int k = 0; k < 24; k++) if (tbl[k][0] == i) return 8'(tbl[k][1]);
    return 8'h00;
  endfunction

  function automatic logic [7:0] expect_read(input logic [7:0] idx);
    return (int'(idx) < NREG) ? model[idx] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q / 2);
    acked = (sda_bus == 1'b0);
    wq(Q - Q / 2);
    m_scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      m_scl = 1'b1; wq(Q / 2);
      b[i] = sda_bus;
      wq(Q - Q / 2);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_scl = 1'b0;
  endtask

  task automatic write_reg(input logic [7:0] idx, input logic [7:0] d, input string req);
    bit a;
    bus_start();
    send_byte(8'h22, a); chk(a, {req, " address ack"}, a, 1);
    send_byte(idx, a);   chk(a, {req, " index ack"}, a, 1);
    send_byte(d, a);     chk(a, {req, " data ack"}, a, 1);
    bus_stop();
    if (int'(idx) < NREG) model[idx] = d;
  endtask

  task automatic set_index(input logic [7:0] idx, input bit rep_start);
    bit a;
    bus_start();
    send_byte(8'h22, a); chk(a, "R2 address ack", a, 1);
    send_byte(idx, a);   chk(a, "R6 index ack", a, 1);
    if (!rep_start) bus_stop();
  endtask

  task automatic read_now(output logic [7:0] d);
    bit a;
    bus_start();
    send_byte(8'h23, a); chk(a, "R4 read address ack", a, 1);
    recv_byte(d);
    bus_stop();
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NREG; i++)
      chk(regs[i*8 +: 8] == model[i], req, regs[i*8 +: 8], model[i]);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1..all act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    bit a;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NREG; i++) model[i] = power_up(i);
    wq(5);
    rst_n = 1'b1;
    wq(5);

    // R1: defaults after reset and line released
    chk(sda_oe == 1'b0, "R1 line released", sda_oe, 0);
    check_bank("R1 default");

    // R2, R3: directed write and bank update
    write_reg(8'h03, 8'hA5, "R3");
    chk(regs[8*3 +: 8] == 8'hA5, "R3 written value", regs[8*3 +: 8], 8'hA5);

    // R4, R6: index persists across stop, read returns it
    set_index(8'h03, 1'b0);
    read_now(d);
    chk(d == 8'hA5, "R4 R6 read after stop", d, 8'hA5);
    set_index(8'h1A, 1'b0);
    read_now(d);
    chk(d == 8'h94, "R4 read default", d, 8'h94);
    read_now(d);
    chk(d == 8'h94, "R6 index kept for second read", d, 8'h94);

    // R8: repeated start read
    set_index(8'h25, 1'b1);
    read_now(d);
    chk(d == 8'h14, "R8 repeated start read", d, 8'h14);

    // R6: unmapped index
    write_reg(8'h30, 8'h5A, "R6");
    check_bank("R6 unmapped write no change");
    set_index(8'h30, 1'b0);
    read_now(d);
    chk(d == 8'h00, "R6 unmapped read", d, 0);

    // R5: foreign address ignored, trailing bytes too
    bus_start();
    send_byte(8'h24, a); chk(!a, "R5 foreign address no ack", a, 0);
    send_byte(8'h05, a); chk(!a, "R5 trailing byte no ack", a, 0);
    send_byte(8'hFF, a); chk(!a, "R5 trailing data no ack", a, 0);
    bus_stop();
    check_bank("R5 bank unchanged");

    // R7: second data byte neither acked nor stored
    bus_start();
    send_byte(8'h22, a); chk(a, "R7 address ack", a, 1);
    send_byte(8'h09, a); chk(a, "R7 index ack", a, 1);
    send_byte(8'h3C, a); chk(a, "R7 first data ack", a, 1);
    send_byte(8'hC3, a); chk(!a, "R7 second data no ack", a, 0);
    bus_stop();
    model[9] = 8'h3C;
    check_bank("R7 only first byte stored");
    chk(sda_oe == 1'b0, "R9 line released after stop", sda_oe, 0);

    // random write / read-back mix
    for (int it = 0; it < 28; it++) begin
      logic [7:0] idx, dat;
      idx = 8'($urandom_range(0, 47));
      dat = 8'($urandom);
      write_reg(idx, dat, "R3 random");
      set_index(idx, it[0]);
      read_now(d);
      chk(d == expect_read(idx), it[0] ? "R8 random read" : "R4 random read",
          d, expect_read(idx));
    end
    check_bank("R3 random bank");
    chk(sda_oe == 1'b0, "R9 idle line", sda_oe, 0);

    finish_run();
  end

endmodule